// File: doc/BRIEF.md
# Narrow-to-Wide Packing FIFO with Exact Stop Level

This block is a single-clock FIFO that takes 16-bit words on its write side and hands out 128-bit words on its read side. Eight accepted write words are assembled into one wide entry, the first in the lowest slice. Only complete entries are stored in the buffer and counted. The buffer holds 256 wide entries.

The occupancy count is given in wide entries and is exact in every cycle, from empty to completely full. A stop-write output rises as soon as the count reaches a threshold input. Upstream logic that writes only while `wr_ready` is high therefore stores exactly as many entries as the threshold, no more and no fewer. The threshold is read on every cycle, so it can be changed while the FIFO is running. A read request returns its data one cycle after it is accepted.

Top module: `pack_fifo`

## Requirements
- R1: A wide entry becomes visible on `level` at the clock edge that accepts its eighth 16-bit write. `level` counts stored wide entries and changes by at most one per cycle.
- R2: Slice order: the first accepted write of a group lands in `rd_data[15:0]`, and each later write lands in the next higher 16-bit slice, up to `rd_data[127:112]`.
- R3: Capacity is 256 wide entries. At `level` == 256, `full` is 1 and `wr_ready` is 0. Writes offered while full are ignored and leave `level` at 256.
- R4: `stop_wr` is 1 whenever `level` >= `limit`, and `wr_ready` is then 0. With `limit` at 200 and writes offered continuously, exactly 1600 writes are accepted and `level` settles at 200.
- R5: After reset, `level` is 0, `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R6: A group of fewer than eight accepted writes is not counted in `level` and cannot be read. `empty` stays 1 if no complete entry exists.
- R7: A read accepted in the same cycle as a write that completes an entry leaves `level` unchanged.
- R8: A read request while `empty` is 1 is ignored: no `rd_valid` pulse follows, and `level` stays 0.
- R9: If `limit` is lowered below the current `level`, `stop_wr` stays 1 until reads bring `level` below `limit`. It then falls in the same cycle.
- R10: An accepted read (`rd_req` with `empty` at 0) gives a one-cycle `rd_valid` pulse on the next cycle, with the oldest stored entry on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Narrow write offered |
| wr_data | input | 16 | Narrow write word |
| wr_ready | output | 1 | Write is accepted this cycle if wr_valid is high |
| rd_req | input | 1 | Read request for one wide entry |
| rd_data | output | 128 | Wide entry returned by the read |
| rd_valid | output | 1 | rd_data holds a newly read entry |
| limit | input | 9 | Threshold, in wide entries, at which writing stops |
| level | output | 9 | Exact count of stored wide entries |
| stop_wr | output | 1 | level has reached limit |
| full | output | 1 | level equals capacity |
| empty | output | 1 | No complete entry stored |

## Verification
The hardest case to reach from the ports is a read and an entry-completing write landing on the same edge. The bench first places exactly seven slices into the packer while one entry is stored, then raises the eighth write and a read request together on one cycle. The exact-threshold behaviour is reached by offering writes on every cycle, far past the point where the block must stop, and counting how many it accepts. It is then checked again after lowering the threshold below the fill level and draining the FIFO one entry at a time. Filling all 256 entries with the threshold set above capacity exercises the full boundary, and every drained entry is compared against the scoreboard.

// File: rtl/pack_fifo_pkg.sv
package pack_fifo_pkg;
  // Per-cycle effect on the stored-entry count
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/pack_fifo_packer.sv
module pack_fifo_packer #(
  parameter int IN_W  = 16,
  parameter int RATIO = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept,
  input  logic [IN_W-1:0]       din,
  output logic                  commit,
  output logic [IN_W*RATIO-1:0] word
);
  localparam int OUT_W  = IN_W * RATIO;
  localparam int LANE_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [LANE_W-1:0] LAST = LANE_W'(RATIO - 1);

  logic [LANE_W-1:0] lane;
  logic [OUT_W-1:0]  hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= '0;
      hold <= '0;
    end else if (accept) begin
      for (int i = 0; i < RATIO; i++) begin
        if (lane == LANE_W'(i)) hold[i*IN_W +: IN_W] <= din;
      end
      lane <= (lane == LAST) ? '0 : lane + 1'b1;
    end
  end

  assign commit = accept && (lane == LAST);

  // The top slice comes straight from the completing write
  for (genvar g = 0; g < RATIO; g++) begin : g_slice
    if (g == RATIO - 1) begin : g_top
      assign word[g*IN_W +: IN_W] = din;
    end else begin : g_low
      assign word[g*IN_W +: IN_W] = hold[g*IN_W +: IN_W];
    end
  end
endmodule

// File: rtl/pack_fifo_store.sv
module pack_fifo_store #(
  parameter int W     = 128,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         re,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  // No reset on the array or read register, so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
    if (re) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (we) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (re) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/pack_fifo_level.sv
module pack_fifo_level
  import pack_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          stop
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  cnt_op_e       op;
  logic [CW-1:0] nxt;

  always_comb begin
    op = CNT_HOLD;
    if (inc && !dec) op = CNT_INC;
    if (dec && !inc) op = CNT_DEC;
    unique case (op)
      CNT_INC: nxt = level + 1'b1;
      CNT_DEC: nxt = level - 1'b1;
      default: nxt = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      level <= nxt;
      empty <= (nxt == '0);
      full  <= (nxt == CAP);
    end
  end

  // The threshold is taken live every cycle
  assign stop = (level >= limit);
endmodule

// File: rtl/pack_fifo.sv
module pack_fifo #(
  parameter int IN_W  = 16,
  parameter int RATIO = 8,
  parameter int DEPTH = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  input  logic [IN_W-1:0]               wr_data,
  output logic                          wr_ready,
  input  logic                          rd_req,
  output logic [IN_W*RATIO-1:0]         rd_data,
  output logic                          rd_valid,
  input  logic [$clog2(DEPTH+1)-1:0]    limit,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          stop_wr,
  output logic                          full,
  output logic                          empty
);
  localparam int OUT_W = IN_W * RATIO;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             accept;
  logic             commit;
  logic             rd_go;
  logic [OUT_W-1:0] packed_word;

  assign wr_ready = !stop_wr && !full;
  assign accept   = wr_valid && wr_ready;
  assign rd_go    = rd_req && !empty;

  pack_fifo_packer #(.IN_W(IN_W), .RATIO(RATIO)) u_packer (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .din    (wr_data),
    .commit (commit),
    .word   (packed_word)
  );

  pack_fifo_store #(.W(OUT_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (commit),
    .wdata  (packed_word),
    .re     (rd_go),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

  pack_fifo_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk   (clk),
    .rst   (rst),
    .inc   (commit),
    .dec   (rd_go),
    .limit (limit),
    .level (level),
    .empty (empty),
    .full  (full),
    .stop  (stop_wr)
  );
endmodule

// File: rtl/pack_fifo_chk.sv
module pack_fifo_chk #(
  parameter int DEPTH = 256
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_ready,
  input logic                       rd_req,
  input logic                       rd_valid,
  input logic                       empty,
  input logic                       full,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic [$clog2(DEPTH+1)-1:0] limit
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_ready);

  assert_stop_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (level >= limit) |-> !wr_ready);

  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    ##1 ((level == $past(level)) || (level == $past(level) + 1'b1) ||
         (level + 1'b1 == $past(level))));

  assert_empty_read_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> !rd_valid);

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !empty) |=> rd_valid);
endmodule

bind pack_fifo pack_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_ready (wr_ready),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .empty    (empty),
  .full     (full),
  .level    (level),
  .limit    (limit)
);

// File: tb/pack_fifo_bench.sv
`timescale 1ns/1ps
module pack_fifo_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic [15:0]  wr_data = '0;
  logic         wr_ready;
  logic         rd_req = 1'b0;
  logic [127:0] rd_data;
  logic         rd_valid;
  logic [8:0]   limit = 9'd200;
  logic [8:0]   level;
  logic         stop_wr;
  logic         full;
  logic         empty;

  int checks = 0;
  int fails  = 0;
  int seq    = 0;
  int lane   = 0;
  logic [127:0] asm_word = '0;
  logic [127:0] exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  pack_fifo u_pack_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .limit(limit), .level(level), .stop_wr(stop_wr),
    .full(full), .empty(empty)
  );

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: offers n narrow writes, one per cycle, and records accepted ones
  task automatic write_lanes(int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 16'h1000 + 16'(seq);
      #1;
      if (wr_ready) begin
        asm_word[lane*16 +: 16] = wr_data;
        seq++; lane++; acc++;
        if (lane == 8) begin
          exp_q.push_back(asm_word);
          lane = 0;
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_words(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_req = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // Monitor: compares each returned entry with the scoreboard (R10)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10/R8 unexpected read data", rd_data, '0);
      else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R10 read order/data", rd_data, e);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      check(1'b0, "watchdog expired", '0, '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int acc;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    check(level == 0, "R5 level after reset", level, 0);
    check(empty == 1, "R5 empty after reset", empty, 1);
    check(full == 0, "R5 full after reset", full, 0);
    check(rd_valid == 0, "R5 rd_valid after reset", rd_valid, 0);

    // R1 / R2: one full group
    write_lanes(7, acc);
    check(level == 0, "R1 level before eighth write", level, 0);
    write_lanes(1, acc);
    check(level == 1, "R1 level after eighth write", level, 1);
    read_words(1);
    check(rd_data[15:0] == 16'h1000, "R2 first slice low", rd_data[15:0], 16'h1000);
    check(rd_data[127:112] == 16'h1007, "R2 last slice high", rd_data[127:112], 16'h1007);

    // R6 / R8: partial group not visible, empty read ignored
    write_lanes(5, acc);
    check(level == 0, "R6 partial not counted", level, 0);
    check(empty == 1, "R6 still empty", empty, 1);
    read_words(1);
    check(rd_valid == 0, "R8 no rd_valid on empty read", rd_valid, 0);
    check(level == 0, "R8 level unchanged", level, 0);

    // R7: read together with a completing write
    write_lanes(3, acc);
    check(level == 1, "R6 completed group counted", level, 1);
    write_lanes(7, acc);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 16'h1000 + 16'(seq); rd_req = 1'b1;
    #1;
    if (wr_ready) begin
      asm_word[lane*16 +: 16] = wr_data;
      seq++; lane++;
      if (lane == 8) begin exp_q.push_back(asm_word); lane = 0; end
    end
    @(negedge clk);
    wr_valid = 1'b0; rd_req = 1'b0;
    check(level == 1, "R7 level unchanged on read+complete", level, 1);
    read_words(1);
    check(level == 0, "R7 drained", level, 0);

    // R4: exact stop at 200
    write_lanes(1700, acc);
    check(acc == 1600, "R4 accepted writes", acc, 1600);
    check(level == 200, "R4 level at threshold", level, 200);
    check(stop_wr == 1 && wr_ready == 0, "R4 stop asserted", {stop_wr, wr_ready}, 2'b10);

    // R9: lowering the threshold
    @(negedge clk);
    limit = 9'd150;
    #1;
    check(stop_wr == 1, "R9 stop held after lowering", stop_wr, 1);
    read_words(50);
    check(level == 150 && stop_wr == 1, "R9 stop at equal level", {level, stop_wr}, {9'd150, 1'b1});
    read_words(1);
    check(level == 149 && stop_wr == 0 && wr_ready == 1, "R9 stop released",
          {level, stop_wr, wr_ready}, {9'd149, 1'b0, 1'b1});

    // R3: fill to capacity with threshold above it
    @(negedge clk);
    limit = 9'd300;
    write_lanes(107 * 8 + 16, acc);
    check(acc == 856, "R3 accepted writes up to capacity", acc, 856);
    check(level == 256 && full == 1, "R3 full at 256", {level, full}, {9'd256, 1'b1});
    check(wr_ready == 0, "R3 wr_ready low when full", wr_ready, 0);
    read_words(256);
    @(negedge clk);
    check(level == 0 && empty == 1, "R3 drained to empty", {level, empty}, {9'd0, 1'b1});
    check(exp_q.size() == 0, "R10 all entries returned", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule